// File: doc/BRIEF.md
# DRAM Bus Cycle Classifier

This block watches the control strobes of an asynchronous DRAM bus (row strobe, upper and lower column strobes, write enable and output enable) without driving anything. It samples the pins on a fast local clock through a synchronizer chain. For every period in which the row strobe is low, it works out what kind of bus cycle took place. When the row strobe rises again, it reports the cycle type and the byte lanes that were touched on a single-cycle pulse.

The two column strobes are merged for mode decisions. The merged strobe is active from the first lane that falls until the last lane that rises. Lanes are still accumulated one by one for the reported mask. A separate single-cycle error pulse carries a violation code in two cases: when the two column strobes fall too far apart within one access, and when write enable falls while output enable is still driving the bus.

The monitor is meant for bus checkers and for trace capture next to a DRAM controller. It holds no memory contents and checks only the order of edges, not analog timing.

Top module: `dram_cycle_mon`

## Requirements
- R1: After reset, `cycValid`, `errValid`, `cycType` and `laneMask` are all zero. Each report on `cycValid` lasts exactly one clock, and it is issued only when the synchronized row strobe rises after a low period.
- R2: If neither column strobe goes low at any point while the row strobe is low, the cycle is reported as row-only refresh (type 6) with lane mask 00.
- R3: If a column strobe is already low in the sample where the row strobe falls, the cycle is reported as column-before-row refresh (type 7) with mask 00. This holds when only the upper strobe is used.
- R4: A column-before-row refresh whose row-low period lasts at least SELF_MIN samples is reported as self-refresh (type 0) with mask 00. A period of SELF_MIN-1 samples still gives type 7.
- R5: An access where write enable stays high is reported as a read (type 1) if output enable was low in any sample while the merged column strobe was low. Otherwise it is reported as a read with output disabled (type 2).
- R6: If write enable is low in the sample where the merged column strobe first falls, the access is an early write (type 3). This includes the case where write enable and the column strobe fall in the same sample.
- R7: If write enable falls after the column strobe and output enable was never low before that fall, the access is a delayed write (type 4).
- R8: If write enable falls after the column strobe and output enable was low in an earlier sample of the access, the access is a read-modify-write (type 5).
- R9: Lane mask bit 0 stands for the lower strobe (low byte) and bit 1 for the upper strobe (high byte). Each bit is set if its strobe was low in any sample of the row-low period, so several page accesses accumulate into the mask.
- R10: During an access, if the second column strobe falls more than STAGGER_MAX samples after the first, an error pulse with code 1 is issued. A gap of STAGGER_MAX samples or less gives no error.
- R11: If write enable falls during an access while output enable is low in that same sample, an error pulse with code 2 is issued. The cycle is still classified by R7 or R8.
- R12: If both violations occur in the same sample, exactly one error pulse is issued and it carries code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe pin, active low, asynchronous |
| ucasN | input | 1 | Upper-byte column strobe pin, active low |
| lcasN | input | 1 | Lower-byte column strobe pin, active low |
| weN | input | 1 | Write enable pin, active low |
| oeN | input | 1 | Output enable pin, active low |
| cycValid | output | 1 | One-clock pulse carrying a cycle report |
| cycType | output | 3 | Cycle type code, valid with cycValid |
| laneMask | output | 2 | Byte lanes touched, valid with cycValid |
| errValid | output | 1 | One-clock violation pulse |
| errCode | output | 2 | Violation code, valid with errValid |

## Verification
Two events can land in the same sample. The first pair is a write-enable fall and the first fall of the merged column strobe, which must resolve to an early write. The second pair is a stagger violation and an output-enable contention, which must give one error pulse with code 1. The bench provokes each case by changing both pins in the same drive step, so they pass through the synchronizer together. It then judges the reported type, the lane mask, the error code, and the number of pulses seen. Around these cases the bench sweeps every lane selection against every access kind, along with the stagger and self-refresh boundaries.

// File: rtl/dram_mon_pkg.sv
package dram_mon_pkg;

  typedef enum logic [2:0] {
    CY_SELF       = 3'd0,
    CY_READ       = 3'd1,
    CY_READ_OFF   = 3'd2,
    CY_EARLY_WR   = 3'd3,
    CY_DELAYED_WR = 3'd4,
    CY_RMW        = 3'd5,
    CY_RAS_ONLY   = 3'd6,
    CY_CBR        = 3'd7
  } cycle_e;

  localparam logic [1:0] ERR_STAGGER  = 2'd1;
  localparam logic [1:0] ERR_OE_WRITE = 2'd2;

  // Bus events seen by the control, derived from the synchronized pins.
  typedef struct packed {
    logic rasFall;
    logic rasRise;
    logic casAnyFall;
    logic casAny;
    logic weFall;
    logic weLow;
    logic oeLow;
    logic longRas;
  } bus_evt_t;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic   emit;
    logic   maskOn;
    logic   clrLanes;
    logic   trackLanes;
    logic   chkStagger;
    logic   flagOe;
    cycle_e code;
  } ctl_strobe_t;

endpackage

// File: rtl/dram_mon_datapath.sv
module dram_mon_datapath
  import dram_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAGGER_MAX = 2,
  parameter int SELF_MIN    = 1600
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  pinsIn,     // {ras, ucas, lcas, we, oe}, active low
  input  ctl_strobe_t ctl,
  output bus_evt_t    evt,
  output logic        cycValid,
  output cycle_e      cycType,
  output logic [1:0]  laneMask,
  output logic        errValid,
  output logic [1:0]  errCode
);

  localparam int STG_W = $clog2(STAGGER_MAX + 2);
  localparam int RAS_W = $clog2(SELF_MIN + 1);
  localparam logic [STG_W-1:0] STG_SAT = STG_W'(STAGGER_MAX + 1);
  localparam logic [STG_W-1:0] STG_LIM = STG_W'(STAGGER_MAX);
  localparam logic [RAS_W-1:0] RAS_SAT = RAS_W'(SELF_MIN);

  logic [4:0] syncQ [SYNC_STAGES];

  // Synchronizer chain; reset to the inactive (high) level.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= '1;
        else       syncQ[g] <= pinsIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= '1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic sRas, sU, sL, sWe, sOe;
  logic pRas, pU, pL, pWe;
  assign {sRas, sU, sL, sWe, sOe} = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) {pRas, pU, pL, pWe} <= '1;
    else       {pRas, pU, pL, pWe} <= {sRas, sU, sL, sWe};
  end

  logic [1:0] lowNow, lowPrev;
  assign lowNow  = {~sU, ~sL};
  assign lowPrev = {~pU, ~pL};

  logic [RAS_W-1:0] rasCnt;
  logic [STG_W-1:0] stgCnt;
  logic [1:0]       lanes;

  always_comb begin
    evt.rasFall    = ~sRas & pRas;
    evt.rasRise    = sRas & ~pRas;
    evt.casAny     = |lowNow;
    evt.casAnyFall = (|lowNow) & ~(|lowPrev);
    evt.weFall     = ~sWe & pWe;
    evt.weLow      = ~sWe;
    evt.oeLow      = ~sOe;
    evt.longRas    = (rasCnt == RAS_SAT);
  end

  // Row-low length counter, saturating at SELF_MIN.
  always_ff @(posedge clk) begin
    if (!rstN || sRas)        rasCnt <= '0;
    else if (rasCnt != RAS_SAT) rasCnt <= rasCnt + 1'b1;
  end

  // Samples spent with exactly one column strobe low.
  always_ff @(posedge clk) begin
    if (!rstN || lowNow == 2'b00)            stgCnt <= '0;
    else if ((^lowNow) && stgCnt != STG_SAT) stgCnt <= stgCnt + 1'b1;
  end

  logic staggerHit;
  assign staggerHit = ctl.chkStagger && (&lowNow) && (^lowPrev) && (stgCnt > STG_LIM);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrLanes) lanes <= 2'b00;
    else if (ctl.trackLanes)   lanes <= lanes | lowNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycValid <= 1'b0;
      cycType  <= CY_SELF;
      laneMask <= 2'b00;
      errValid <= 1'b0;
      errCode  <= 2'b00;
    end else begin
      cycValid <= ctl.emit;
      errValid <= staggerHit | ctl.flagOe;
      if (ctl.emit) begin
        cycType  <= ctl.code;
        laneMask <= ctl.maskOn ? (lanes | lowNow) : 2'b00;
      end
      if (staggerHit)      errCode <= ERR_STAGGER;
      else if (ctl.flagOe) errCode <= ERR_OE_WRITE;
    end
  end

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |=> !cycValid);

  p_refresh_nomask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && (cycType == CY_RAS_ONLY || cycType == CY_CBR || cycType == CY_SELF))
      |-> laneMask == 2'b00);

  p_access_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycType inside {CY_READ, CY_READ_OFF, CY_EARLY_WR, CY_DELAYED_WR, CY_RMW})
      |-> laneMask != 2'b00);

  p_err_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errCode == ERR_STAGGER || errCode == ERR_OE_WRITE));

endmodule

// File: rtl/dram_mon_ctrl.sv
module dram_mon_ctrl
  import dram_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  bus_evt_t    evt,
  output ctl_strobe_t ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_ACCESS, ST_CBR} state_e;

  state_e state;
  cycle_e typ;
  logic   oeSeen;
  logic   wrDecide;
  logic   active;

  assign active   = (state == ST_ROW) || (state == ST_ACCESS);
  assign wrDecide = (state == ST_ACCESS) && evt.casAny && evt.weFall &&
                    (typ == CY_READ || typ == CY_READ_OFF);

  always_comb begin
    ctl            = '0;
    ctl.emit       = evt.rasRise && (state != ST_IDLE);
    ctl.maskOn     = (state == ST_ACCESS);
    ctl.clrLanes   = (state == ST_IDLE) && evt.rasFall;
    ctl.trackLanes = active;
    ctl.chkStagger = active;
    ctl.flagOe     = wrDecide && evt.oeLow;
    case (state)
      ST_CBR:    ctl.code = evt.longRas ? CY_SELF : CY_CBR;
      ST_ACCESS: ctl.code = typ;
      default:   ctl.code = CY_RAS_ONLY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      typ    <= CY_READ_OFF;
      oeSeen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (evt.rasFall) state <= evt.casAny ? ST_CBR : ST_ROW;
        ST_ROW: begin
          if (evt.rasRise) state <= ST_IDLE;
          else if (evt.casAnyFall) begin
            state  <= ST_ACCESS;
            oeSeen <= evt.oeLow;
            if (evt.weLow)      typ <= CY_EARLY_WR;
            else if (evt.oeLow) typ <= CY_READ;
            else                typ <= CY_READ_OFF;
          end
        end
        ST_ACCESS: begin
          if (evt.rasRise) state <= ST_IDLE;
          else if (wrDecide) typ <= oeSeen ? CY_RMW : CY_DELAYED_WR;
          else if (evt.casAny && evt.oeLow) begin
            oeSeen <= 1'b1;
            if (typ == CY_READ_OFF) typ <= CY_READ;
          end
        end
        default: if (evt.rasRise) state <= ST_IDLE;
      endcase
    end
  end

  p_early_sticks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS && typ == CY_EARLY_WR) |=> (typ == CY_EARLY_WR || state == ST_IDLE));

  p_rmw_needs_oe_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS && typ == CY_RMW) |-> oeSeen);

endmodule

// File: rtl/dram_cycle_mon.sv
module dram_cycle_mon
  import dram_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAGGER_MAX = 2,
  parameter int SELF_MIN    = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       ucasN,
  input  logic       lcasN,
  input  logic       weN,
  input  logic       oeN,
  output logic       cycValid,
  output logic [2:0] cycType,
  output logic [1:0] laneMask,
  output logic       errValid,
  output logic [1:0] errCode
);

  bus_evt_t    evt;
  ctl_strobe_t ctl;
  cycle_e      typeOut;

  dram_mon_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .STAGGER_MAX(STAGGER_MAX),
    .SELF_MIN   (SELF_MIN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinsIn  ({rasN, ucasN, lcasN, weN, oeN}),
    .ctl     (ctl),
    .evt     (evt),
    .cycValid(cycValid),
    .cycType (typeOut),
    .laneMask(laneMask),
    .errValid(errValid),
    .errCode (errCode)
  );

  dram_mon_ctrl u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .evt (evt),
    .ctl (ctl)
  );

  assign cycType = typeOut;

endmodule

// File: tb/sim_dram_cycle_mon.sv
`timescale 1ns/1ps
module sim_dram_cycle_mon;

  localparam int STG  = 2;
  localparam int SELF = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, ucasN = 1'b1, lcasN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic cycValid, errValid;
  logic [2:0] cycType;
  logic [1:0] laneMask, errCode;

  int checks = 0;
  int errors = 0;
  int nRep = 0, nErr = 0;
  int lastType = -1, lastMask = -1, lastErr = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_cycle_mon #(.SYNC_STAGES(2), .STAGGER_MAX(STG), .SELF_MIN(SELF)) u0 (
    .clk(clk), .rstN(rstN), .rasN(rasN), .ucasN(ucasN), .lcasN(lcasN),
    .weN(weN), .oeN(oeN), .cycValid(cycValid), .cycType(cycType),
    .laneMask(laneMask), .errValid(errValid), .errCode(errCode)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (cycValid) begin
        nRep++; lastType = int'(cycType); lastMask = int'(laneMask);
      end
      if (errValid) begin
        nErr++; lastErr = int'(errCode);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearObs();
    nRep = 0; nErr = 0; lastType = -1; lastMask = -1; lastErr = -1;
  endtask

  task automatic release_all();
    rasN = 1'b1; step(1);
    ucasN = 1'b1; lcasN = 1'b1; weN = 1'b1; oeN = 1'b1;
    step(8);
  endtask

  task automatic lanesLow(input int sel);
    if (sel[0]) lcasN = 1'b0;
    if (sel[1]) ucasN = 1'b0;
  endtask

  // kind: 0 read, 1 read off, 2 early write, 3 delayed write, 4 rmw
  task automatic access(input int sel, input int kind);
    clearObs();
    rasN = 1'b0; step(2);
    if (kind == 2) weN = 1'b0;
    lanesLow(sel); step(2);
    case (kind)
      0: begin oeN = 1'b0; step(3); end
      1: step(3);
      2: step(3);
      3: begin weN = 1'b0; step(3); end
      default: begin oeN = 1'b0; step(2); oeN = 1'b1; step(1); weN = 1'b0; step(2); end
    endcase
    release_all();
  endtask

  task automatic cbr(input int sel, input int lowLen);
    clearObs();
    lanesLow(sel); step(2);
    rasN = 1'b0; step(lowLen);
    release_all();
  endtask

  task automatic stagger(input int gap);
    clearObs();
    rasN = 1'b0; step(2);
    lcasN = 1'b0; step(gap);
    ucasN = 1'b0; step(3);
    release_all();
  endtask

  initial begin
    step(4);
    rstN = 1'b1;
    step(1);
    chk("R1 reset cycValid", int'(cycValid), 0);
    chk("R1 reset errValid", int'(errValid), 0);
    chk("R1 reset laneMask", int'(laneMask), 0);
    chk("R1 reset cycType", int'(cycType), 0);

    // R2 row-only refresh
    clearObs();
    rasN = 1'b0; step(6);
    release_all();
    chk("R1 one pulse per row period", nRep, 1);
    chk("R2 row-only type", lastType, 6);
    chk("R2 row-only mask", lastMask, 0);

    // R3 / R4 refresh with column first
    cbr(1, 10);
    chk("R3 cbr type", lastType, 7);
    chk("R3 cbr mask", lastMask, 0);
    cbr(2, 10);
    chk("R3 cbr upper only type", lastType, 7);
    cbr(1, SELF - 1);
    chk("R4 just below self threshold", lastType, 7);
    cbr(3, SELF);
    chk("R4 self at threshold", lastType, 0);
    chk("R4 self mask", lastMask, 0);
    cbr(1, SELF + 20);
    chk("R4 self long", lastType, 0);

    // R5-R9 sweep: every lane selection against every access kind
    for (int sel = 1; sel <= 3; sel++) begin
      for (int kind = 0; kind <= 4; kind++) begin
        access(sel, kind);
        chk("R1 sweep pulse count", nRep, 1);
        chk((kind == 0) ? "R5 read type" : (kind == 1) ? "R5 read off type" :
            (kind == 2) ? "R6 early type" : (kind == 3) ? "R7 delayed type" : "R8 rmw type",
            lastType, kind + 1);
        chk("R9 sweep lane mask", lastMask, sel);
        chk("R10 sweep no error", nErr, 0);
      end
    end

    // R6 write enable and column strobe fall in the same sample
    clearObs();
    rasN = 1'b0; step(2);
    weN = 1'b0; lcasN = 1'b0; step(3);
    release_all();
    chk("R6 same-sample early type", lastType, 3);
    chk("R6 same-sample mask", lastMask, 1);

    // R9 page accesses accumulate lanes
    clearObs();
    rasN = 1'b0; step(2);
    lcasN = 1'b0; step(2); lcasN = 1'b1; step(2);
    ucasN = 1'b0; step(2); ucasN = 1'b1; step(2);
    release_all();
    chk("R9 page accumulate mask", lastMask, 3);
    chk("R9 page type", lastType, 2);

    // R10 stagger boundary
    for (int gap = 1; gap <= STG + 2; gap++) begin
      stagger(gap);
      chk("R10 stagger error count", nErr, (gap > STG) ? 1 : 0);
      if (gap > STG) chk("R10 stagger code", lastErr, 1);
      chk("R10 stagger still reports mask", lastMask, 3);
    end

    // R11 write enable falls with output enable low
    clearObs();
    rasN = 1'b0; step(2);
    lanesLow(3); oeN = 1'b0; step(3);
    weN = 1'b0; step(2);
    release_all();
    chk("R11 contention error count", nErr, 1);
    chk("R11 contention code", lastErr, 2);
    chk("R11 contention type", lastType, 5);

    // R11 output enable falls together with write enable: delayed write
    clearObs();
    rasN = 1'b0; step(2);
    lanesLow(1); step(3);
    weN = 1'b0; oeN = 1'b0; step(2);
    release_all();
    chk("R11 late oe code", lastErr, 2);
    chk("R11 late oe type", lastType, 4);

    // R12 stagger and contention in the same sample
    clearObs();
    rasN = 1'b0; step(2);
    lcasN = 1'b0; oeN = 1'b0; step(STG + 2);
    ucasN = 1'b0; weN = 1'b0; step(3);
    release_all();
    chk("R12 single error pulse", nErr, 1);
    chk("R12 stagger wins", lastErr, 1);
    chk("R12 type", lastType, 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule